// File: doc/BRIEF.md
# Solid Rectangle Fill Engine

This block paints a rectangular area of frame memory with one constant colour. A request is made by presenting the destination start address, the byte distance between rows, the row width in bytes, the number of rows, a bytes-per-pixel code, four colour bytes and two mode bytes, then pulsing `start` for one clock. The block first decides whether the request is a solid fill. If it is not, the request is passed on to the ordinary copy path with a one-clock `copy_req` pulse, and the engine stays idle.

A solid fill writes one byte per clock through a byte-wide synchronous write port. It walks each row from left to right and steps the row base by the pitch. The colour byte for each position is chosen by its byte lane within the pixel. When the last byte has been written, `done` pulses for one clock and carries the region that was painted, so that the display side can redraw it. The engine then returns to idle.

All request inputs are captured on the accepted `start` edge. They may change freely while the fill runs.

Top module: `rect_fill_engine`

## Requirements
- R1: After reset, `busy`, `done`, `mem_we` and `copy_req` are all low.
- R2: An idle `start` is a solid fill only when `mode_ext` bit 2 is set and, of the `mode` bits 1 (host destination), 3 (transparency), 6 (pattern) and 7 (expansion), exactly bits 6 and 7 are set. Other `mode` bits do not matter. An accepted fill raises `busy` in the next cycle.
- R3: An idle `start` that is not a solid fill produces a one-clock `copy_req` in the next cycle, with no memory write and `busy` low.
- R4: When `pix_code` is 1 (one byte per pixel), every written byte equals `color0`.
- R5: When `pix_code` is 2, the bytes of each row alternate `color0`, `color1`, which is little-endian order.
- R6: When `pix_code` is 3, each pixel is written as `color0`, `color1`, `color2` in sequence.
- R7: When `pix_code` is 4, or any value other than 1, 2 or 3, each pixel is written as `color0` to `color3` in sequence.
- R8: Row r writes the bytes `dst_addr + r*dst_pitch + x`, modulo the address space. Here x runs upward from 0 over floor(`byte_width`/pixel size) whole pixels. Bytes left over at the end of a row are not written. Rows are written in increasing order.
- R9: `busy` stays high from the cycle after an accepted fill through the `done` cycle. A `start` while `busy` is high is ignored.
- R10: `done` is a one-clock pulse in the cycle after the final write. While it is high, `done_addr`, `done_pitch`, `done_width` and `done_rows` give the captured request. `busy` is low in the following cycle.
- R11: A fill with zero rows, or with a row too narrow to hold one pixel, writes nothing and pulses `done` in the cycle after `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe |
| mode | input | 8 | Operation mode byte |
| mode_ext | input | 8 | Extended mode byte (bit 2 selects solid fill) |
| pix_code | input | 3 | Bytes per pixel: 1, 2 or 3; any other value means 4 |
| dst_addr | input | AW | Destination start address |
| dst_pitch | input | AW | Address step between rows |
| byte_width | input | WW | Row width in bytes |
| row_count | input | HW | Number of rows |
| color0 | input | 8 | Colour byte, lane 0 |
| color1 | input | 8 | Colour byte, lane 1 |
| color2 | input | 8 | Colour byte, lane 2 |
| color3 | input | 8 | Colour byte, lane 3 |
| busy | output | 1 | Fill in progress |
| mem_we | output | 1 | Byte write enable |
| mem_addr | output | AW | Byte write address |
| mem_wdata | output | 8 | Byte write data |
| copy_req | output | 1 | One-clock pass-on to the copy path |
| done | output | 1 | One-clock end-of-fill pulse |
| done_addr | output | AW | Region start address |
| done_pitch | output | AW | Region pitch |
| done_width | output | WW | Region byte width |
| done_rows | output | HW | Region row count |

## Verification
The assertions expect `rst_n` to be held low over the first clocks. They check that consecutive writes within a row step the address by exactly one. This relies on the row-end marker the walker brings out, so that the jump made by the pitch at a row change is exempt. The acceptance properties decide for themselves whether a `start` is a fill, using the mode-bit rule, and they apply only to a `start` seen while `busy` is low. The stimulus raises `start` for one clock at a time and waits for each request to finish before the next one. The only exception is a deliberate `start` pulse in the middle of a fill. Widths, row counts and pitches are kept small so that each fill ends within a few hundred clocks. Start addresses include values near the top of the address space, so that wrap-around is exercised.

// File: rtl/rect_fill_pkg.sv
package rect_fill_pkg;

  localparam int MB_HOSTDST = 1;
  localparam int MB_TRANSP  = 3;
  localparam int MB_PATTERN = 6;
  localparam int MB_EXPAND  = 7;
  localparam int EB_SOLID   = 2;
  localparam int LANES      = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_DONE = 2'd2
  } fill_state_e;

  // Solid fill: extension flag set, and among the four qualifying mode bits
  // exactly pattern and expansion are set.
  function automatic logic fill_selected(input logic [7:0] mode_b,
                                         input logic [7:0] ext_b);
    logic [7:0] mask;
    logic [7:0] want;
    mask = '0;
    want = '0;
    mask[MB_HOSTDST] = 1'b1;
    mask[MB_TRANSP]  = 1'b1;
    mask[MB_PATTERN] = 1'b1;
    mask[MB_EXPAND]  = 1'b1;
    want[MB_PATTERN] = 1'b1;
    want[MB_EXPAND]  = 1'b1;
    return ext_b[EB_SOLID] && ((mode_b & mask) == want);
  endfunction

  // Bytes per pixel: 1..3 taken as given, everything else means 4.
  function automatic logic [2:0] pix_size(input logic [2:0] code);
    case (code)
      3'd1:    return 3'd1;
      3'd2:    return 3'd2;
      3'd3:    return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/fill_decode.sv
module fill_decode
  import rect_fill_pkg::*;
(
  input  logic [7:0] mode,
  input  logic [7:0] mode_ext,
  input  logic [2:0] pix_code,
  output logic       is_fill,
  output logic [2:0] pix_bytes
);

  always_comb begin
    is_fill   = fill_selected(mode, mode_ext);
    pix_bytes = pix_size(pix_code);
  end

endmodule

// File: rtl/fill_lane.sv
module fill_lane
  import rect_fill_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] color_in [LANES],
  input  logic [1:0] lane,
  output logic [7:0] byte_out
);

  logic [7:0] color_q [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_color
    always_ff @(posedge clk) begin
      if (!rst_n)    color_q[i] <= '0;
      else if (load) color_q[i] <= color_in[i];
    end
  end

  assign byte_out = color_q[lane];

endmodule

// File: rtl/fill_walker.sv
module fill_walker
  import rect_fill_pkg::*;
#(
  parameter int AW = 16,
  parameter int WW = 12,
  parameter int HW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] dst,
  input  logic [AW-1:0] pitch,
  input  logic [WW-1:0] width,
  input  logic [HW-1:0] rows,
  input  logic [2:0]    pb,
  output logic          idle,
  output logic          busy,
  output logic          write_evt,
  output logic          row_wrap,
  output logic          done,
  output logic [AW-1:0] addr,
  output logic [1:0]    lane,
  output logic [AW-1:0] reg_addr,
  output logic [AW-1:0] reg_pitch,
  output logic [WW-1:0] reg_width,
  output logic [HW-1:0] reg_rows
);

  // Bytes actually written per row: whole pixels only.
  function automatic logic [WW-1:0] row_span(input logic [WW-1:0] w,
                                             input logic [2:0]    p);
    logic [WW-1:0] pw;
    pw = WW'(p);
    return (w / pw) * pw;
  endfunction

  fill_state_e   state;
  logic [AW-1:0] base;
  logic [WW-1:0] x;
  logic [WW-1:0] span_q;
  logic [HW-1:0] row;
  logic [2:0]    pb_q;
  logic [WW-1:0] span_in;
  logic          last_row;
  logic          lane_end;

  assign span_in   = row_span(width, pb);
  assign idle      = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign write_evt = (state == ST_FILL);
  assign done      = (state == ST_DONE);
  assign row_wrap  = write_evt && (x == span_q - WW'(1));
  assign last_row  = (row == reg_rows - HW'(1));
  assign lane_end  = ({1'b0, lane} == pb_q - 3'd1);
  assign addr      = base + AW'(x);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      base      <= '0;
      x         <= '0;
      span_q    <= '0;
      row       <= '0;
      pb_q      <= 3'd1;
      lane      <= '0;
      reg_addr  <= '0;
      reg_pitch <= '0;
      reg_width <= '0;
      reg_rows  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (go) begin
            base      <= dst;
            reg_addr  <= dst;
            reg_pitch <= pitch;
            reg_width <= width;
            reg_rows  <= rows;
            pb_q      <= pb;
            span_q    <= span_in;
            x         <= '0;
            row       <= '0;
            lane      <= '0;
            state     <= (rows == '0 || span_in == '0) ? ST_DONE : ST_FILL;
          end
        end
        ST_FILL: begin
          if (row_wrap) begin
            x    <= '0;
            lane <= '0;
            base <= base + reg_pitch;
            row  <= row + HW'(1);
            if (last_row) state <= ST_DONE;
          end else begin
            x    <= x + WW'(1);
            lane <= lane_end ? 2'd0 : lane + 2'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine
  import rect_fill_pkg::*;
#(
  parameter int AW = 16,
  parameter int WW = 12,
  parameter int HW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    mode,
  input  logic [7:0]    mode_ext,
  input  logic [2:0]    pix_code,
  input  logic [AW-1:0] dst_addr,
  input  logic [AW-1:0] dst_pitch,
  input  logic [WW-1:0] byte_width,
  input  logic [HW-1:0] row_count,
  input  logic [7:0]    color0,
  input  logic [7:0]    color1,
  input  logic [7:0]    color2,
  input  logic [7:0]    color3,
  output logic          busy,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          copy_req,
  output logic          done,
  output logic [AW-1:0] done_addr,
  output logic [AW-1:0] done_pitch,
  output logic [WW-1:0] done_width,
  output logic [HW-1:0] done_rows
);

  logic       is_fill;
  logic [2:0] pix_bytes;
  logic       idle;
  logic       accept_fill;
  logic       accept_copy;
  logic       row_wrap;
  logic [1:0] lane;
  logic [7:0] color_in [LANES];

  assign color_in[0] = color0;
  assign color_in[1] = color1;
  assign color_in[2] = color2;
  assign color_in[3] = color3;

  fill_decode u_decode (
    .mode      (mode),
    .mode_ext  (mode_ext),
    .pix_code  (pix_code),
    .is_fill   (is_fill),
    .pix_bytes (pix_bytes)
  );

  assign accept_fill = start && idle && is_fill;
  assign accept_copy = start && idle && !is_fill;

  always_ff @(posedge clk) begin
    if (!rst_n) copy_req <= 1'b0;
    else        copy_req <= accept_copy;
  end

  fill_walker #(.AW(AW), .WW(WW), .HW(HW)) u_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (accept_fill),
    .dst       (dst_addr),
    .pitch     (dst_pitch),
    .width     (byte_width),
    .rows      (row_count),
    .pb        (pix_bytes),
    .idle      (idle),
    .busy      (busy),
    .write_evt (mem_we),
    .row_wrap  (row_wrap),
    .done      (done),
    .addr      (mem_addr),
    .lane      (lane),
    .reg_addr  (done_addr),
    .reg_pitch (done_pitch),
    .reg_width (done_width),
    .reg_rows  (done_rows)
  );

  fill_lane u_lane (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_fill),
    .color_in (color_in),
    .lane     (lane),
    .byte_out (mem_wdata)
  );

endmodule

// File: rtl/rect_fill_chk.sv
module rect_fill_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [7:0]    mode,
  input logic [7:0]    mode_ext,
  input logic          busy,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          row_wrap,
  input logic          copy_req,
  input logic          done
);

  logic want_fill;
  assign want_fill = mode_ext[2] && ((mode & 8'hCA) == 8'hC0);

  a_r2_fill_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && want_fill) |=> busy);

  a_r3_copy_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !want_fill) |=> (copy_req && !busy));

  a_r3_copy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    copy_req |-> (!busy && !mem_we));

  a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && !$past(row_wrap)) |->
      (mem_addr == $past(mem_addr) + AW'(1)));

  a_r9_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !copy_req);

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r10_done_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_we);

endmodule

bind rect_fill_engine rect_fill_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .mode     (mode),
  .mode_ext (mode_ext),
  .busy     (busy),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .row_wrap (row_wrap),
  .copy_req (copy_req),
  .done     (done)
);

// File: tb/rect_fill_engine_test.sv
`timescale 1ns/1ps
module rect_fill_engine_test;

  localparam int AW = 16;
  localparam int WW = 12;
  localparam int HW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [7:0]    mode = '0, mode_ext = '0;
  logic [2:0]    pix_code = 3'd1;
  logic [AW-1:0] dst_addr = '0, dst_pitch = '0;
  logic [WW-1:0] byte_width = '0;
  logic [HW-1:0] row_count = '0;
  logic [7:0]    color0 = '0, color1 = '0, color2 = '0, color3 = '0;
  logic          busy, mem_we, copy_req, done;
  logic [AW-1:0] mem_addr, done_addr, done_pitch;
  logic [7:0]    mem_wdata;
  logic [WW-1:0] done_width;
  logic [HW-1:0] done_rows;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rect_fill_engine #(.AW(AW), .WW(WW), .HW(HW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .mode_ext(mode_ext),
    .pix_code(pix_code), .dst_addr(dst_addr), .dst_pitch(dst_pitch),
    .byte_width(byte_width), .row_count(row_count),
    .color0(color0), .color1(color1), .color2(color2), .color3(color3),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .copy_req(copy_req), .done(done), .done_addr(done_addr),
    .done_pitch(done_pitch), .done_width(done_width), .done_rows(done_rows)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_fill(input logic [7:0] m, input logic [7:0] e);
    return e[2] && m[7] && m[6] && !m[3] && !m[1];
  endfunction

  function automatic int exp_pb(input logic [2:0] c);
    if (c >= 3'd1 && c <= 3'd3) return int'(c);
    return 4;
  endfunction

  function automatic string stream_tag(input int pb);
    case (pb)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  // One request; if inject is set, a non-fill start is pulsed two cycles into a fill.
  task automatic run_case(input int d, input int p, input int w, input int r,
                          input int code, input int m, input int e,
                          input int c0, input int c1, input int c2, input int c3,
                          input bit inject);
    int pb, span, total, k, bad, n, bad_a, bad_d, ea, ed;
    bit fill, busy_ok, copy_seen;
    logic [7:0] col [4];
    @(negedge clk);
    dst_addr = AW'(d); dst_pitch = AW'(p); byte_width = WW'(w); row_count = HW'(r);
    pix_code = 3'(code); mode = 8'(m); mode_ext = 8'(e);
    color0 = 8'(c0); color1 = 8'(c1); color2 = 8'(c2); color3 = 8'(c3);
    col[0] = 8'(c0); col[1] = 8'(c1); col[2] = 8'(c2); col[3] = 8'(c3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fill = exp_fill(8'(m), 8'(e));
    if (!fill) begin
      chk(copy_req && !busy && !mem_we, "R3", int'(copy_req), 1);
      chk(!busy, "R2", int'(busy), 0);
      @(negedge clk);
      chk(!copy_req && !busy && !mem_we, "R3", int'(copy_req), 0);
      return;
    end
    chk(busy, "R2", int'(busy), 1);
    pb = exp_pb(3'(code));
    span = (w / pb) * pb;
    total = r * span;
    k = 0; bad = 0; n = 0; bad_a = 0; bad_d = 0;
    busy_ok = 1; copy_seen = 0;
    while (!done && n < 5000) begin
      if (!busy) busy_ok = 0;
      if (copy_req) copy_seen = 1;
      if (mem_we) begin
        ea = (d + (k / span) * p + (k % span)) & 32'hFFFF;
        ed = int'(col[(k % span) % pb]);
        if (k < total && (int'(mem_addr) != ea || int'(mem_wdata) != ed)) begin
          if (bad == 0) begin bad_a = int'(mem_addr); bad_d = int'(mem_wdata); end
          bad++;
        end
        k++;
      end
      if (inject) begin
        start = (n == 2);
        mode = 8'h00;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    if (copy_req) copy_seen = 1;
    chk(bad == 0, stream_tag(pb), bad_d, bad_a);
    chk(k == total, "R8", k, total);
    chk(busy_ok && busy, "R9", int'(busy_ok), 1);
    if (inject) chk(!copy_seen, "R9", int'(copy_seen), 0);
    if (total == 0) chk(n == 0 && done, "R11", n, 0);
    chk(done && !mem_we && done_addr == AW'(d) && done_pitch == AW'(p) &&
        done_width == WW'(w) && done_rows == HW'(r), "R10", int'(done_addr), d);
    @(negedge clk);
    chk(!done && !busy && !copy_req, "R10", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED1);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !mem_we && !copy_req, "R1", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_we && !copy_req, "R1", int'(done), 0);

    // directed: each pixel size, remainder bytes, unknown codes
    run_case(16'h0100, 64, 5, 3, 1, 8'hC0, 8'h04, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 0);
    run_case(16'h0200, 32, 7, 2, 2, 8'hC0, 8'h04, 8'h11, 8'h22, 8'h33, 8'h44, 0);
    run_case(16'h0300, 40, 10, 2, 3, 8'hC0, 8'h04, 8'h5A, 8'h6B, 8'h7C, 8'h8D, 0);
    run_case(16'h0400, 16, 8, 2, 4, 8'hC0, 8'h04, 8'h01, 8'h02, 8'h03, 8'h04, 0);
    run_case(16'h0500, 16, 9, 1, 0, 8'hC0, 8'h04, 8'h91, 8'h92, 8'h93, 8'h94, 0);
    run_case(16'h0600, 16, 8, 1, 6, 8'hC0, 8'h04, 8'hE1, 8'hE2, 8'hE3, 8'hE4, 0);
    // R2: unrelated mode bits do not block a fill
    run_case(16'h0700, 8, 3, 2, 1, 8'hE5, 8'hFF, 8'h3C, 0, 0, 0, 0);
    // R2/R3: non-fill requests
    run_case(16'h0800, 8, 4, 2, 1, 8'hC0, 8'h00, 8'h55, 0, 0, 0, 0);
    run_case(16'h0800, 8, 4, 2, 1, 8'hC8, 8'h04, 8'h55, 0, 0, 0, 0);
    run_case(16'h0800, 8, 4, 2, 1, 8'h40, 8'h04, 8'h55, 0, 0, 0, 0);
    run_case(16'h0800, 8, 4, 2, 1, 8'hC2, 8'h04, 8'h55, 0, 0, 0, 0);
    // R11: empty fills
    run_case(16'h0900, 8, 6, 0, 1, 8'hC0, 8'h04, 8'h77, 0, 0, 0, 0);
    run_case(16'h0900, 8, 2, 3, 4, 8'hC0, 8'h04, 8'h77, 0, 0, 0, 0);
    // R9: start during a fill is ignored
    run_case(16'h0A00, 20, 12, 3, 2, 8'hC0, 8'h04, 8'hCA, 8'hFE, 0, 0, 1);
    // R8: address wrap at top of space
    run_case(16'hFFFA, 100, 9, 2, 3, 8'hC0, 8'h04, 8'h10, 8'h20, 8'h30, 0, 0);

    // constrained random
    for (int i = 0; i < 40; i++) begin
      int m, e;
      m = (($urandom % 4) == 0) ? int'($urandom % 256) : (8'hC0 | int'($urandom % 256 & 8'h35));
      e = (($urandom % 5) == 0) ? 0 : (4 | int'($urandom % 256));
      run_case(int'($urandom % 65536), int'($urandom % 80), int'($urandom % 41),
               int'($urandom % 7), int'($urandom % 8), m, e,
               int'($urandom % 256), int'($urandom % 256),
               int'($urandom % 256), int'($urandom % 256), ($urandom % 6) == 0);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule